// File: doc/BRIEF.md
# Data-Processing Second-Operand Shifter

This block forms the second source operand of a data-processing instruction, together with the shifter carry that logical flag-setting operations pick up. It receives the instruction word, the value read from the register named in the low nibble, the low byte of the register that supplies a variable shift amount, and the current carry flag. It does not read registers, compute the ALU result or write any flags.

The operand comes from one of three sources, picked by instruction bits. The first is an 8-bit constant rotated right by an even amount. The second is the register value shifted by a 5-bit constant. The third is the register value shifted by the byte amount. Encodings with a zero constant amount take on special meanings. Register amounts of 32 or more have their own result and carry rules. The parameter `REG_OUT` selects a registered result with one cycle of latency (the default) or a purely combinational one.

Top module: `shf_operand2`

## Requirements
- R1: With `REG_OUT`=1, the operand and carry for the inputs present at a rising clock edge appear at the outputs after that edge. While `rst_n` is low, both outputs are 0.
- R2: When instr bit 25 is 1, the operand is instr[7:0] zero-extended and rotated right by 2*instr[11:8]. The carry is the incoming carry if that amount is 0, and bit 31 of the operand otherwise.
- R3: When bit 25 is 0, instr[6:5] selects the shift kind: 00 left logical, 01 right logical, 10 right arithmetic, 11 rotate right. instr[4]=1 takes the amount from `rs_lo_i`. instr[4]=0 takes it from instr[11:7]. All other instruction bits have no effect.
- R4: A constant left shift by 0 passes the register value unchanged with the incoming carry. A constant left shift by n from 1 to 31 gives value<<n, with carry equal to value bit 32-n.
- R5: A constant right logical or arithmetic shift by n from 1 to 31 gives the shifted value, with carry equal to value bit n-1.
- R6: A constant right logical or arithmetic shift with amount field 0 shifts by 32. The logical kind gives 0 and the arithmetic kind gives 32 copies of bit 31. In both cases the carry is value bit 31.
- R7: A constant rotate by n from 1 to 31 rotates the value right by n, with carry equal to value bit n-1.
- R8: A constant rotate with amount field 0 is a one-place rotate through carry. The operand is {carry_in, value[31:1]} and the carry is value bit 0.
- R9: A register amount of 0 passes the value unchanged with the incoming carry, for every shift kind.
- R10: A register left or right logical shift by 1 to 31 behaves as in R4 and R5. At exactly 32 the result is 0, with carry equal to value bit 0 (left) or bit 31 (right). Above 32 the result and carry are both 0.
- R11: A register arithmetic right shift by 32 or more gives 32 copies of value bit 31, with carry equal to value bit 31.
- R12: A register rotate with a nonzero byte whose low 5 bits are 0 passes the value unchanged with carry equal to value bit 31. Any other nonzero byte rotates by its low 5 bits, with carry equal to value bit (low5-1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 32 | Instruction word |
| rm_i | input | 32 | Value of the register to be shifted |
| rs_lo_i | input | 8 | Low byte of the register that supplies the shift amount |
| carry_i | input | 1 | Current carry flag |
| op2_o | output | 32 | Second operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The bench targets the encodings whose meaning changes when the amount is zero. A design that treats constant right shifts literally would pass the value through instead of producing 0 or a sign fill. A design that decodes a rotate of zero as a plain rotate would drop the incoming carry out of bit 31.

The bench also probes register amounts of 31, 32, 33 and large bytes such as 0x40 and 0xE0. A design that truncates the byte to 5 bits would shift instead of clearing the result, and would give the wrong carry at exactly 32. A design that ignores the upper bits on rotates would return the incoming carry instead of bit 31 of the value.

Carry selection for rotated constants is exercised with rotation fields of zero and nonzero. Random words with random condition and unused bits surround all of these directed cases.

// File: rtl/shf_pkg.sv
package shf_pkg;
   localparam int WORD_W = 32;
   localparam int AMT_W  = 8;
   localparam int IMM_W  = 8;
   localparam int ROT_W  = 4;
   localparam int SH5_W  = 5;

   typedef enum logic [1:0] {
      SK_LSL = 2'b00,
      SK_LSR = 2'b01,
      SK_ASR = 2'b10,
      SK_ROR = 2'b11
   } shkind_e;

   typedef struct packed {
      logic               is_imm;
      shkind_e            kind;
      logic               by_reg;
      logic               pass;
      logic               rrx;
      logic [AMT_W-1:0]   amt;
      logic [IMM_W-1:0]   imm8;
      logic [ROT_W-1:0]   rot;
   } shctl_t;

   typedef struct packed {
      logic [WORD_W-1:0] val;
      logic              cy;
   } shres_t;
endpackage

// File: rtl/shf_rotr.sv
module shf_rotr #(
   parameter int  W          = 32,
   parameter bit  LOG_STAGES = 1'b1,
   localparam int SW         = $clog2(W)
) (
   input  logic [W-1:0]  din,
   input  logic [SW-1:0] amt,
   output logic [W-1:0]  dout
);
   generate
      if ((1 << SW) != W) begin : g_bad_w
         $error("shf_rotr: W must be a power of two");
      end
      if (LOG_STAGES) begin : g_log
         logic [W-1:0] stg [SW+1];
         assign stg[0] = din;
         for (genvar s = 0; s < SW; s++) begin : g_stage
            localparam int D = 1 << s;
            assign stg[s+1] = amt[s] ? {stg[s][D-1:0], stg[s][W-1:D]} : stg[s];
         end
         assign dout = stg[SW];
      end else begin : g_flat
         logic [2*W-1:0] dbl;
         assign dbl  = {din, din} >> amt;
         assign dout = dbl[W-1:0];
      end
   endgenerate
endmodule

// File: rtl/shf_decode.sv
module shf_decode
   import shf_pkg::*;
#(
   parameter int IW = 32
) (
   input  logic [IW-1:0]    instr,
   input  logic [AMT_W-1:0] rs_lo,
   output shctl_t           ctl
);
   localparam logic [AMT_W-1:0] FULL_SHIFT = AMT_W'(WORD_W);

   generate
      if (IW < 26) begin : g_bad_iw
         $error("shf_decode: instruction word too narrow");
      end
   endgenerate

   logic [SH5_W-1:0] imm5;

   always_comb begin
      imm5       = instr[11:7];
      ctl.is_imm = instr[25];
      ctl.kind   = shkind_e'(instr[6:5]);
      ctl.by_reg = instr[4];
      ctl.imm8   = instr[IMM_W-1:0];
      ctl.rot    = instr[11:8];
      ctl.rrx    = 1'b0;
      if (ctl.by_reg) begin
         ctl.amt = rs_lo;
      end else begin
         ctl.amt = AMT_W'(imm5);
         if (imm5 == '0) begin
            unique case (ctl.kind)
               SK_LSR, SK_ASR: ctl.amt = FULL_SHIFT;
               SK_ROR:         ctl.rrx = 1'b1;
               default:        ctl.amt = '0;
            endcase
         end
      end
      ctl.pass = (ctl.amt == '0) && !ctl.rrx;
   end
endmodule

// File: rtl/shf_core.sv
module shf_core
   import shf_pkg::*;
#(
   parameter int W          = WORD_W,
   parameter bit LOG_STAGES = 1'b1
) (
   input  shctl_t        ctl,
   input  logic [W-1:0]  rm,
   input  logic          cin,
   output shres_t        res
);
   localparam int SW = $clog2(W);

   logic [W:0]   lsl_ext;
   logic [W:0]   lsr_ext;
   logic [W:0]   asr_ext;
   logic [W-1:0] ror_val;

   shf_rotr #(.W(W), .LOG_STAGES(LOG_STAGES)) u_rot (
      .din  (rm),
      .amt  (ctl.amt[SW-1:0]),
      .dout (ror_val)
   );

   always_comb begin
      lsl_ext = {1'b0, rm} << ctl.amt;
      lsr_ext = {rm, 1'b0} >> ctl.amt;
      asr_ext = $signed({rm, 1'b0}) >>> ctl.amt;
   end

   always_comb begin
      res.val = rm;
      res.cy  = cin;
      if (ctl.rrx) begin
         res.val = {cin, rm[W-1:1]};
         res.cy  = rm[0];
      end else if (!ctl.pass) begin
         unique case (ctl.kind)
            SK_LSL: begin res.val = lsl_ext[W-1:0]; res.cy = lsl_ext[W]; end
            SK_LSR: begin res.val = lsr_ext[W:1];   res.cy = lsr_ext[0]; end
            SK_ASR: begin res.val = asr_ext[W:1];   res.cy = asr_ext[0]; end
            default: begin res.val = ror_val;       res.cy = ror_val[W-1]; end
         endcase
      end
   end
endmodule

// File: rtl/shf_operand2.sv
module shf_operand2
   import shf_pkg::*;
#(
   parameter int DW         = 32,
   parameter bit REG_OUT    = 1'b1,
   parameter bit LOG_STAGES = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [31:0]   instr_i,
   input  logic [DW-1:0] rm_i,
   input  logic [7:0]    rs_lo_i,
   input  logic          carry_i,
   output logic [DW-1:0] op2_o,
   output logic          carry_o
);
   localparam int SW = $clog2(DW);

   generate
      if (DW != WORD_W) begin : g_bad_dw
         $error("shf_operand2: DW must equal the package word width");
      end
   endgenerate

   shctl_t        ctl;
   shres_t        sh_res;
   logic [DW-1:0] imm_rot;
   logic [DW-1:0] nxt_val;
   logic          nxt_cy;

   shf_decode #(.IW(32)) u_dec (
      .instr (instr_i),
      .rs_lo (rs_lo_i),
      .ctl   (ctl)
   );

   shf_core #(.W(DW), .LOG_STAGES(LOG_STAGES)) u_core (
      .ctl (ctl),
      .rm  (rm_i),
      .cin (carry_i),
      .res (sh_res)
   );

   shf_rotr #(.W(DW), .LOG_STAGES(LOG_STAGES)) u_imm_rot (
      .din  (DW'(ctl.imm8)),
      .amt  (SW'({ctl.rot, 1'b0})),
      .dout (imm_rot)
   );

   always_comb begin
      if (ctl.is_imm) begin
         nxt_val = imm_rot;
         nxt_cy  = (ctl.rot == '0) ? carry_i : imm_rot[DW-1];
      end else begin
         nxt_val = sh_res.val;
         nxt_cy  = sh_res.cy;
      end
   end

   logic [31:0]   chk_instr;
   logic [DW-1:0] chk_rm;
   logic [7:0]    chk_rs;
   logic          chk_cin;

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               op2_o     <= '0;
               carry_o   <= 1'b0;
               chk_instr <= '0;
               chk_rm    <= '0;
               chk_rs    <= '0;
               chk_cin   <= 1'b0;
            end else begin
               op2_o     <= nxt_val;
               carry_o   <= nxt_cy;
               chk_instr <= instr_i;
               chk_rm    <= rm_i;
               chk_rs    <= rs_lo_i;
               chk_cin   <= carry_i;
            end
         end

         // R1
         reset_clear_chk: assert property (@(posedge clk)
            !rst_n |-> (op2_o == '0) && !carry_o);
      end else begin : g_comb
         assign op2_o     = nxt_val;
         assign carry_o   = nxt_cy;
         assign chk_instr = instr_i;
         assign chk_rm    = rm_i;
         assign chk_rs    = rs_lo_i;
         assign chk_cin   = carry_i;
      end
   endgenerate

   // R2
   imm_norot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_instr[25] && chk_instr[11:8] == 4'd0)
      |-> (op2_o == DW'(chk_instr[7:0])) && (carry_o == chk_cin));

   // R2
   imm_rot_cy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_instr[25] && chk_instr[11:8] != 4'd0) |-> (carry_o == op2_o[DW-1]));

   // R4
   lsl_zero_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!chk_instr[25] && !chk_instr[4] && chk_instr[6:5] == 2'b00 && chk_instr[11:7] == 5'd0)
      |-> (op2_o == chk_rm) && (carry_o == chk_cin));

   // R6
   lsr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!chk_instr[25] && !chk_instr[4] && chk_instr[6:5] == 2'b01 && chk_instr[11:7] == 5'd0)
      |-> (op2_o == '0) && (carry_o == chk_rm[DW-1]));

   // R8
   rrx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!chk_instr[25] && !chk_instr[4] && chk_instr[6:5] == 2'b11 && chk_instr[11:7] == 5'd0)
      |-> (op2_o == {chk_cin, chk_rm[DW-1:1]}) && (carry_o == chk_rm[0]));

   // R9
   reg_zero_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!chk_instr[25] && chk_instr[4] && chk_rs == 8'd0)
      |-> (op2_o == chk_rm) && (carry_o == chk_cin));

   // R10
   reg_logic_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!chk_instr[25] && chk_instr[4] && !chk_instr[6] && chk_rs > 8'd32)
      |-> (op2_o == '0) && !carry_o);

   // R11
   reg_asr_big_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!chk_instr[25] && chk_instr[4] && chk_instr[6:5] == 2'b10 && chk_rs >= 8'd32)
      |-> (op2_o == {DW{chk_rm[DW-1]}}) && (carry_o == chk_rm[DW-1]));

   // R12
   reg_ror_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!chk_instr[25] && chk_instr[4] && chk_instr[6:5] == 2'b11 &&
       chk_rs != 8'd0 && chk_rs[4:0] == 5'd0)
      |-> (op2_o == chk_rm) && (carry_o == chk_rm[DW-1]));
endmodule

// File: tb/shf_operand2_tb.sv
module shf_operand2_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] instr = '0;
   logic [31:0] rm = '0;
   logic [7:0]  rs = '0;
   logic        cin = 1'b0;
   logic [31:0] op2;
   logic        cy;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   shf_operand2 u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .instr_i (instr),
      .rm_i    (rm),
      .rs_lo_i (rs),
      .carry_i (cin),
      .op2_o   (op2),
      .carry_o (cy)
   );

   function automatic logic [31:0] rot_m(input logic [31:0] x, input int n);
      logic [31:0] r;
      for (int i = 0; i < 32; i++) r[i] = x[(i + n) % 32];
      return r;
   endfunction

   function automatic logic [32:0] model(input logic [31:0] ir, input logic [31:0] v,
                                         input logic [7:0] s, input logic c);
      logic [63:0] t;
      logic [31:0] o;
      logic        k;
      int          n;
      int          r;
      o = v;
      k = c;
      if (ir[25]) begin
         n = 2 * int'(ir[11:8]);
         o = rot_m({24'b0, ir[7:0]}, n);
         k = (n == 0) ? c : o[31];
      end else begin
         n = ir[4] ? int'(s) : int'(ir[11:7]);
         if (!ir[4] && n == 0 && (ir[6:5] == 2'b01 || ir[6:5] == 2'b10)) n = 32;
         if (!ir[4] && n == 0 && ir[6:5] == 2'b11) begin
            o = {c, v[31:1]};
            k = v[0];
         end else if (n != 0) begin
            case (ir[6:5])
               2'b00: begin t = {32'b0, v} << n; o = t[31:0]; k = t[32]; end
               2'b01: begin t = {v, 32'b0} >> n; o = t[63:32]; k = t[31]; end
               2'b10: begin
                  t = $signed({v, 32'b0}) >>> ((n > 32) ? 32 : n);
                  o = t[63:32]; k = t[31];
               end
               default: begin
                  r = n % 32;
                  if (r == 0) begin o = v; k = v[31]; end
                  else begin o = rot_m(v, r); k = v[r-1]; end
               end
            endcase
         end
      end
      return {k, o};
   endfunction

   task automatic apply(input logic [31:0] ir, input logic [31:0] v, input logic [7:0] s,
                        input logic c, input string tag);
      logic [32:0] exp;
      @(negedge clk);
      instr = ir; rm = v; rs = s; cin = c;
      exp = model(ir, v, s, c);
      @(negedge clk);
      n_cmp++;
      if ({cy, op2} !== exp) begin
         n_bad++;
         $display("FAIL %s: instr=%h rm=%h rs=%h cin=%0d got op2=%h cy=%0d expected op2=%h cy=%0d",
                  tag, ir, v, s, c, op2, cy, exp[31:0], exp[32]);
      end
   endtask

   function automatic logic [31:0] shf_ir(input logic [1:0] kind, input bit by_reg,
                                          input logic [4:0] imm5);
      return {4'hE, 3'b000, 4'b1101, 1'b0, 4'h0, 4'h1, imm5, kind, by_reg, 4'h2};
   endfunction

   initial begin
      void'($urandom(32'd20251));
      instr = 32'hE3A0_00FF; rm = 32'hFFFF_FFFF; cin = 1'b1;
      repeat (3) @(negedge clk);
      // R1: outputs held at zero in reset
      n_cmp++;
      if (op2 !== 32'h0 || cy !== 1'b0) begin
         n_bad++;
         $display("FAIL R1: op2=%h cy=%0d expected op2=00000000 cy=0", op2, cy);
      end
      rst_n = 1'b1;

      // R2: rotated constants
      apply(32'hE3A0_00A5, 32'h1234_5678, 8'h00, 1'b1, "R2");
      apply(32'hE3A0_0F3C, 32'h0, 8'h00, 1'b0, "R2");
      apply(32'hE3A0_0102, 32'h0, 8'h00, 1'b0, "R2");
      apply(32'hE3A0_04FF, 32'h0, 8'h00, 1'b1, "R2");
      // R4: constant left shift
      apply(shf_ir(2'b00, 1'b0, 5'd0), 32'h8000_0001, 8'h00, 1'b1, "R4");
      apply(shf_ir(2'b00, 1'b0, 5'd1), 32'h8000_0001, 8'h00, 1'b0, "R4");
      apply(shf_ir(2'b00, 1'b0, 5'd31), 32'h0000_0003, 8'h00, 1'b0, "R4");
      // R5: constant right shifts
      apply(shf_ir(2'b01, 1'b0, 5'd4), 32'hF000_0008, 8'h00, 1'b0, "R5");
      apply(shf_ir(2'b10, 1'b0, 5'd1), 32'h8000_0001, 8'h00, 1'b0, "R5");
      // R6: zero field means shift by 32
      apply(shf_ir(2'b01, 1'b0, 5'd0), 32'h8765_4321, 8'h00, 1'b0, "R6");
      apply(shf_ir(2'b10, 1'b0, 5'd0), 32'h8765_4321, 8'h00, 1'b0, "R6");
      apply(shf_ir(2'b10, 1'b0, 5'd0), 32'h7765_4321, 8'h00, 1'b1, "R6");
      // R7 / R8: constant rotate and rotate through carry
      apply(shf_ir(2'b11, 1'b0, 5'd8), 32'h1234_5680, 8'h00, 1'b0, "R7");
      apply(shf_ir(2'b11, 1'b0, 5'd0), 32'h0000_0003, 8'h00, 1'b1, "R8");
      apply(shf_ir(2'b11, 1'b0, 5'd0), 32'hFFFF_FFFE, 8'h00, 1'b0, "R8");
      // R9: register amount zero for every kind
      for (int k = 0; k < 4; k++) apply(shf_ir(2'(k), 1'b1, 5'd0), 32'hDEAD_BEEF, 8'h00, 1'b1, "R9");
      // R10: register logical shifts around 32
      apply(shf_ir(2'b00, 1'b1, 5'd0), 32'h0000_0001, 8'd32, 1'b0, "R10");
      apply(shf_ir(2'b00, 1'b1, 5'd0), 32'hFFFF_FFFF, 8'd33, 1'b1, "R10");
      apply(shf_ir(2'b00, 1'b1, 5'd0), 32'h8000_0001, 8'd31, 1'b0, "R10");
      apply(shf_ir(2'b01, 1'b1, 5'd0), 32'h8000_0000, 8'd32, 1'b0, "R10");
      apply(shf_ir(2'b01, 1'b1, 5'd0), 32'hFFFF_FFFF, 8'h40, 1'b1, "R10");
      // R11: register arithmetic shift of 32 or more
      apply(shf_ir(2'b10, 1'b1, 5'd0), 32'h8000_1234, 8'd32, 1'b0, "R11");
      apply(shf_ir(2'b10, 1'b1, 5'd0), 32'h4000_1234, 8'hFF, 1'b1, "R11");
      // R12: register rotate with zero low bits and with wrap
      apply(shf_ir(2'b11, 1'b1, 5'd0), 32'h8000_0010, 8'hE0, 1'b0, "R12");
      apply(shf_ir(2'b11, 1'b1, 5'd0), 32'h0000_0010, 8'h20, 1'b1, "R12");
      apply(shf_ir(2'b11, 1'b1, 5'd0), 32'h0000_0010, 8'h25, 1'b0, "R12");

      // R3: random words, cond and unused bits random, amounts biased to edges
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] w;
         logic [7:0]  a;
         w = $urandom;
         case ($urandom_range(0, 5))
            0: a = 8'd0;
            1: a = 8'd32;
            2: a = 8'(31 + $urandom_range(0, 2));
            3: a = {3'($urandom), 5'd0};
            default: a = 8'($urandom);
         endcase
         if ($urandom_range(0, 3) == 0) w[11:7] = 5'd0;
         if (!w[25] && w[4]) w[7] = 1'b0;
         apply(w, $urandom, a, 1'($urandom), "R3");
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #1_500_000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule